// File: doc/BRIEF.md
# Storage-Qualified Trigger Sequencer Capture

This block is the acquisition front end of a small on-chip logic analyzer. On every clock it may receive a sample: a data word plus an address field, marked by a valid strobe. For each sample it decides two things. First, whether the sample is written into a capture RAM. Second, whether the trigger sequencer moves to another step. The block drives the RAM's write port directly and raises a trigger flag and a done flag.

Storage follows a global default rule, which is either keep everything or keep nothing. Each of the four sequence steps can override that default through its own address window with a keep or discard action. The override applies only to samples inside the window; every other sample falls back to the default. Each step also has a separate advance condition, an address match. It names the next step and can also fire the trigger, so the storage rule in force changes as the sequencer walks through its steps.

Software programs the steps through a small register write port and then pulses `arm`. After the trigger, the block keeps storing until a programmed number of further samples has been kept, then stops.

Top module: `trig_seq_capture`

## Requirements
- R1: After reset, `trig_flag`, `done_flag` and `mem_we` are low, and no sample is written until `arm` has been pulsed.
- R2: A cycle with `arm` high returns the sequencer to step 0, clears the write pointer (the next write goes to address 0), clears `trig_flag` and `done_flag`, and ignores any sample presented in that same cycle.
- R3: With `dflt_store` = 1, every valid sample that falls outside the active step's storage window is stored. With `dflt_store` = 0, such samples are discarded.
- R4: A step's storage window is enabled by control bit 0, and its action is set by control bit 1 (1 = keep, 0 = discard). Register code 0 sets the low bound and code 1 sets the high bound. A sample whose address lies within [low, high], both ends inclusive, follows the step's action and ignores the default.
- R5: A step advances when control bit 2 is set and the sample address equals the match register (register code 2). The next step index is held in control bits 5:4, and the control word is register code 3. The matching sample is qualified by the step it arrived in; the new step governs from the following sample on.
- R6: An advance of a step whose control bit 3 is set also raises `trig_flag`, which is visible from the clock edge that takes the matching sample. It stays high until the next `arm`.
- R7: For each stored sample, `mem_we` is high for exactly the one cycle after the sample's cycle. In that cycle `mem_wdata` carries the sample data, and `mem_waddr` carries the number of samples stored since `arm`, modulo 1024. The pointer moves only when a sample is stored.
- R8: Once `trig_flag` is high and `post_cnt` samples have been stored in cycles where `trig_flag` was already high, the next clock edge sets `done_flag`. From that cycle on, no sample is written and the step no longer changes. With `post_cnt` = 0, `done_flag` rises one edge after `trig_flag`.
- R9: Samples with `smp_valid` low, samples presented before the first `arm`, and samples presented after `done_flag` is set are neither stored nor allowed to move the sequencer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | One-cycle pulse that restarts an acquisition |
| dflt_store | input | 1 | Default rule: 1 keep all, 0 keep none |
| post_cnt | input | 11 | Samples to store after the trigger before stopping |
| cfg_we | input | 1 | Step register write strobe |
| cfg_step | input | 2 | Step being programmed |
| cfg_reg | input | 2 | Register code: 0 low, 1 high, 2 match, 3 control |
| cfg_wdata | input | 16 | Register write value |
| smp_valid | input | 1 | Sample present this cycle |
| smp_addr | input | 16 | Address field of the sample |
| smp_data | input | 16 | Sample data word |
| mem_we | output | 1 | Capture RAM write enable |
| mem_waddr | output | 10 | Capture RAM write address |
| mem_wdata | output | 16 | Capture RAM write data |
| trig_flag | output | 1 | Trigger has fired since arm |
| done_flag | output | 1 | Post-trigger quota reached |

## Verification
A sample presented in cycle k produces its RAM write in cycle k+1, and any trigger it causes is visible on `trig_flag` in cycle k+1 as well. `done_flag` appears one edge after the cycle in which the post-trigger quota is found complete. The bench drives every input at the falling edge and reads outputs at the next falling edge. Its model predicts, per sample, the write item and both flags, so each comparison lands on the cycle in which the result is due. Writes go through a queue that is popped only when `mem_we` is seen, and the bench requires the queue to be empty after each scenario, so late, missing and extra writes are all caught.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

    localparam int ADDR_W = 16;
    localparam int STEP_N = 4;
    localparam int STEP_W = $clog2(STEP_N);

    // register codes on the configuration port
    typedef enum logic [1:0] {
        REG_LO    = 2'd0,
        REG_HI    = 2'd1,
        REG_MATCH = 2'd2,
        REG_CTRL  = 2'd3
    } cfg_reg_e;

    // control word bit positions
    localparam int CTRL_ST_EN  = 0;
    localparam int CTRL_KEEP   = 1;
    localparam int CTRL_ADV_EN = 2;
    localparam int CTRL_TRIG   = 3;
    localparam int CTRL_NEXT   = 4;
    localparam int CTRL_USED   = CTRL_NEXT + STEP_W;

    typedef struct packed {
        logic [ADDR_W-1:0] lo;
        logic [ADDR_W-1:0] hi;
        logic [ADDR_W-1:0] match;
        logic              st_en;
        logic              keep;
        logic              adv_en;
        logic              trig;
        logic [STEP_W-1:0] nxt;
    } step_cfg_t;

    function automatic logic in_window(input logic [ADDR_W-1:0] a,
                                       input logic [ADDR_W-1:0] lo,
                                       input logic [ADDR_W-1:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction

endpackage

// File: rtl/tsc_cfg_regs.sv
module tsc_cfg_regs
    import tsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [STEP_W-1:0] cfg_step,
    input  logic [1:0]        cfg_reg,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output step_cfg_t         cfg_o [STEP_N]
);

    step_cfg_t regs [STEP_N];
    logic      unused_hi_bits;

    assign unused_hi_bits = ^cfg_wdata[ADDR_W-1:CTRL_USED];

    for (genvar s = 0; s < STEP_N; s++) begin : g_step
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[s] <= '0;
            end else if (cfg_we && (cfg_step == STEP_W'(s))) begin
                case (cfg_reg_e'(cfg_reg))
                    REG_LO:    regs[s].lo    <= cfg_wdata;
                    REG_HI:    regs[s].hi    <= cfg_wdata;
                    REG_MATCH: regs[s].match <= cfg_wdata;
                    REG_CTRL: begin
                        regs[s].st_en  <= cfg_wdata[CTRL_ST_EN];
                        regs[s].keep   <= cfg_wdata[CTRL_KEEP];
                        regs[s].adv_en <= cfg_wdata[CTRL_ADV_EN];
                        regs[s].trig   <= cfg_wdata[CTRL_TRIG];
                        regs[s].nxt    <= cfg_wdata[CTRL_NEXT +: STEP_W];
                    end
                    default: ;
                endcase
            end
        end
        assign cfg_o[s] = regs[s];
    end

endmodule

// File: rtl/tsc_qualify.sv
module tsc_qualify
    import tsc_pkg::*;
(
    input  step_cfg_t         cur,
    input  logic [ADDR_W-1:0] addr,
    input  logic              dflt_store,
    output logic              store,
    output logic              hit
);

    logic in_win;

    always_comb begin
        in_win = cur.st_en && in_window(addr, cur.lo, cur.hi);
        // the step overrides the default only inside its own window
        store  = in_win ? cur.keep : dflt_store;
        hit    = cur.adv_en && (addr == cur.match);
    end

endmodule

// File: rtl/tsc_sequencer.sv
module tsc_sequencer
    import tsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              arm,
    input  logic              adv,
    input  logic              trig_act,
    input  logic [STEP_W-1:0] nxt,
    output logic [STEP_W-1:0] step_q,
    output logic              trig_q
);

    always_ff @(posedge clk) begin
        if (rst || arm) begin
            step_q <= '0;
            trig_q <= 1'b0;
        end else if (adv) begin
            step_q <= nxt;
            if (trig_act) trig_q <= 1'b1;
        end
    end

    p_arm_home_r2: assert property (@(posedge clk) disable iff (rst)
        arm |=> (step_q == '0) && !trig_q);

    p_step_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!arm && !adv) |=> $stable(step_q));

    p_trig_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (trig_q && !arm) |=> trig_q);

endmodule

// File: rtl/tsc_capture.sv
module tsc_capture #(
    parameter  int DATA_W    = 16,
    parameter  int MEM_DEPTH = 1024,
    localparam int AW        = $clog2(MEM_DEPTH),
    localparam int CNT_W     = AW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arm,
    input  logic              smp_valid,
    input  logic              store,
    input  logic              trig,
    input  logic [DATA_W-1:0] smp_data,
    input  logic [CNT_W-1:0]  post_cnt,
    output logic              run,
    output logic              done,
    output logic              mem_we,
    output logic [AW-1:0]     mem_waddr,
    output logic [DATA_W-1:0] mem_wdata
);

    logic              armed_q, done_q;
    logic [AW-1:0]     wptr_q;
    logic [CNT_W-1:0]  pcnt_q;
    logic              active, quota_met, wr;

    assign active    = armed_q && !done_q;
    assign quota_met = trig && (pcnt_q == post_cnt);
    assign run       = active && !quota_met;
    assign wr        = run && smp_valid && store;
    assign done      = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q   <= 1'b0;
            done_q    <= 1'b0;
            wptr_q    <= '0;
            pcnt_q    <= '0;
            mem_we    <= 1'b0;
            mem_waddr <= '0;
            mem_wdata <= '0;
        end else if (arm) begin
            armed_q <= 1'b1;
            done_q  <= 1'b0;
            wptr_q  <= '0;
            pcnt_q  <= '0;
            mem_we  <= 1'b0;
        end else begin
            mem_we <= wr;
            if (wr) begin
                mem_waddr <= wptr_q;
                mem_wdata <= smp_data;
                wptr_q    <= (wptr_q == AW'(MEM_DEPTH - 1)) ? '0 : wptr_q + 1'b1;
                if (trig) pcnt_q <= pcnt_q + 1'b1;
            end
            if (active && quota_met) done_q <= 1'b1;
        end
    end

    p_write_follows_r7: assert property (@(posedge clk) disable iff (rst)
        (!arm && wr) |=> mem_we && (mem_wdata == $past(smp_data)));

    p_no_spurious_write_r9: assert property (@(posedge clk) disable iff (rst)
        (!arm && !wr) |=> !mem_we);

    p_done_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (done_q && !arm) |=> done_q);

    p_done_needs_trig_r8: assert property (@(posedge clk) disable iff (rst)
        done_q |-> trig);

    p_arm_clears_r2: assert property (@(posedge clk) disable iff (rst)
        arm |=> !done_q && !mem_we && (wptr_q == '0));

endmodule

// File: rtl/trig_seq_capture.sv
module trig_seq_capture
    import tsc_pkg::*;
#(
    parameter  int DATA_W    = 16,
    parameter  int MEM_DEPTH = 1024,
    localparam int AW        = $clog2(MEM_DEPTH),
    localparam int CNT_W     = AW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arm,
    input  logic              dflt_store,
    input  logic [CNT_W-1:0]  post_cnt,
    input  logic              cfg_we,
    input  logic [STEP_W-1:0] cfg_step,
    input  logic [1:0]        cfg_reg,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              smp_valid,
    input  logic [ADDR_W-1:0] smp_addr,
    input  logic [DATA_W-1:0] smp_data,
    output logic              mem_we,
    output logic [AW-1:0]     mem_waddr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              trig_flag,
    output logic              done_flag
);

    step_cfg_t         cfg [STEP_N];
    step_cfg_t         cur;
    logic [STEP_W-1:0] step_q;
    logic              store, hit, run, adv;

    tsc_cfg_regs u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_step  (cfg_step),
        .cfg_reg   (cfg_reg),
        .cfg_wdata (cfg_wdata),
        .cfg_o     (cfg)
    );

    // only the active step's conditions are evaluated
    assign cur = cfg[step_q];

    tsc_qualify u_qual (
        .cur        (cur),
        .addr       (smp_addr),
        .dflt_store (dflt_store),
        .store      (store),
        .hit        (hit)
    );

    assign adv = run && smp_valid && hit;

    tsc_sequencer u_seq (
        .clk      (clk),
        .rst      (rst),
        .arm      (arm),
        .adv      (adv),
        .trig_act (cur.trig),
        .nxt      (cur.nxt),
        .step_q   (step_q),
        .trig_q   (trig_flag)
    );

    tsc_capture #(
        .DATA_W    (DATA_W),
        .MEM_DEPTH (MEM_DEPTH)
    ) u_cap (
        .clk       (clk),
        .rst       (rst),
        .arm       (arm),
        .smp_valid (smp_valid),
        .store     (store),
        .trig      (trig_flag),
        .smp_data  (smp_data),
        .post_cnt  (post_cnt),
        .run       (run),
        .done      (done_flag),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata)
    );

    p_quiet_after_reset_r1: assert property (@(posedge clk)
        $past(rst) |-> !mem_we && !trig_flag && !done_flag);

endmodule

// File: tb/trig_seq_capture_tb_top.sv
`timescale 1ns/1ps
module trig_seq_capture_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        arm = 1'b0;
    logic        dflt_store = 1'b0;
    logic [10:0] post_cnt = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_step = '0;
    logic [1:0]  cfg_reg = '0;
    logic [15:0] cfg_wdata = '0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_addr = '0;
    logic [15:0] smp_data = '0;
    logic        mem_we;
    logic [9:0]  mem_waddr;
    logic [15:0] mem_wdata;
    logic        trig_flag, done_flag;

    always #2 clk = ~clk;   // 250 MHz

    trig_seq_capture dut_i (
        .clk(clk), .rst(rst), .arm(arm), .dflt_store(dflt_store),
        .post_cnt(post_cnt), .cfg_we(cfg_we), .cfg_step(cfg_step),
        .cfg_reg(cfg_reg), .cfg_wdata(cfg_wdata), .smp_valid(smp_valid),
        .smp_addr(smp_addr), .smp_data(smp_data), .mem_we(mem_we),
        .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .trig_flag(trig_flag), .done_flag(done_flag)
    );

    int    checks = 0;
    int    failures = 0;
    bit    finished = 0;
    string cur_tag = "R9";

    // bench-side model of the programmed steps and run state
    int m_lo[4], m_hi[4], m_match[4], m_nxt[4];
    bit m_sten[4], m_keep[4], m_adv[4], m_trg[4];
    bit m_armed, m_trig, m_done;
    int m_step, m_wptr, m_pcnt;
    logic [25:0] exp_q[$];

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // scoreboard monitor: pops one expected write per observed write
    always @(negedge clk) begin
        if (!rst && mem_we) begin
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL %s unexpected write actual=%0d expected=%0d", cur_tag, mem_waddr, -1);
            end else begin
                logic [25:0] e;
                e = exp_q.pop_front();
                if ({mem_waddr, mem_wdata} !== e) begin
                    failures++;
                    $display("FAIL %s write actual=%0h expected=%0h", cur_tag, {mem_waddr, mem_wdata}, e);
                end
            end
        end
    end

    task automatic model_tick(input bit v, input int a, input int d);
        bit inr, st;
        if (m_armed && !m_done) begin
            if (m_trig && m_pcnt == int'(post_cnt)) begin
                m_done = 1;
            end else if (v) begin
                inr = m_sten[m_step] && a >= m_lo[m_step] && a <= m_hi[m_step];
                st  = inr ? m_keep[m_step] : dflt_store;
                if (st) begin
                    exp_q.push_back({10'(m_wptr), 16'(d)});
                    m_wptr = (m_wptr + 1) % 1024;
                    if (m_trig) m_pcnt++;
                end
                if (m_adv[m_step] && a == m_match[m_step]) begin
                    if (m_trg[m_step]) m_trig = 1;
                    m_step = m_nxt[m_step];
                end
            end
        end
    endtask

    task automatic cycle(input bit v, input int a, input int d);
        smp_valid = v;
        smp_addr  = 16'(a);
        smp_data  = 16'(d);
        model_tick(v, a, d);
        @(posedge clk);
        @(negedge clk);
        smp_valid = 1'b0;
        chk(trig_flag == m_trig, "R6 trig_flag", int'(trig_flag), int'(m_trig));
        chk(done_flag == m_done, "R8 done_flag", int'(done_flag), int'(m_done));
    endtask

    task automatic cfg_write(input int s, input int r, input int val);
        cfg_we = 1'b1; cfg_step = 2'(s); cfg_reg = 2'(r); cfg_wdata = 16'(val);
        case (r)
            0: m_lo[s] = val;
            1: m_hi[s] = val;
            2: m_match[s] = val;
            default: begin
                m_sten[s] = val[0]; m_keep[s] = val[1]; m_adv[s] = val[2];
                m_trg[s] = val[3]; m_nxt[s] = (val >> 4) & 3;
            end
        endcase
        cycle(0, 0, 0);
        cfg_we = 1'b0;
    endtask

    task automatic clear_steps();
        for (int s = 0; s < 4; s++) cfg_write(s, 3, 0);
    endtask

    task automatic do_arm();
        arm = 1'b1;
        smp_valid = 1'b1; smp_addr = 16'd1000; smp_data = 16'hDEAD;  // must be ignored (R2)
        m_armed = 1; m_trig = 0; m_done = 0; m_step = 0; m_wptr = 0; m_pcnt = 0;
        @(posedge clk);
        @(negedge clk);
        arm = 1'b0; smp_valid = 1'b0;
        chk(trig_flag == 1'b0, "R2 trig cleared by arm", int'(trig_flag), 0);
        chk(done_flag == 1'b0, "R2 done cleared by arm", int'(done_flag), 0);
        chk(mem_we == 1'b0, "R2 arm-cycle sample ignored", int'(mem_we), 0);
    endtask

    task automatic drain(input string tag);
        repeat (3) cycle(0, 0, 0);
        chk(exp_q.size() == 0, tag, exp_q.size(), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        m_armed = 0; m_trig = 0; m_done = 0; m_step = 0; m_wptr = 0; m_pcnt = 0;
        for (int s = 0; s < 4; s++) begin
            m_lo[s] = 0; m_hi[s] = 0; m_match[s] = 0; m_nxt[s] = 0;
            m_sten[s] = 0; m_keep[s] = 0; m_adv[s] = 0; m_trg[s] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: quiet after reset
        chk(mem_we == 1'b0, "R1 mem_we after reset", int'(mem_we), 0);
        chk(trig_flag == 1'b0, "R1 trig_flag after reset", int'(trig_flag), 0);
        chk(done_flag == 1'b0, "R1 done_flag after reset", int'(done_flag), 0);

        // R9: samples before the first arm are ignored
        cur_tag = "R9";
        dflt_store = 1'b1;
        for (int i = 0; i < 3; i++) begin
            cycle(1, 5 + i, 16'hA000 + i);
            chk(mem_we == 1'b0, "R9 unarmed sample not written", int'(mem_we), 0);
        end

        // R3 keep-all default, R7 write port, R9 gaps with valid low
        cur_tag = "R3/R7";
        post_cnt = 11'd2047;
        do_arm();
        for (int i = 0; i < 8; i++) begin
            cycle(1, 40 + i, 16'h0100 + i);
            if (i % 3 == 0) cycle(0, 40, 16'hFFFF);
        end
        drain("R7 all writes seen");

        // R3 keep-none default, R4/R5/R6/R8 address-window example
        cur_tag = "R4/R5";
        dflt_store = 1'b0;
        post_cnt = 11'd3;
        cfg_write(0, 2, 1000);
        cfg_write(0, 3, 'h14);          // advance to step 1
        cfg_write(1, 0, 1000);
        cfg_write(1, 1, 2000);
        cfg_write(1, 2, 2500);
        cfg_write(1, 3, 'h1F);          // keep window, advance with trigger to step 1
        do_arm();
        cycle(1, 500, 16'h0001);
        cycle(1, 1000, 16'h0002);       // advances, qualified by step 0: discarded
        cycle(1, 1000, 16'h0003);       // step 1, low edge of window
        cycle(1, 1500, 16'h0004);
        cycle(1, 2000, 16'h0005);       // high edge
        cycle(1, 2001, 16'h0006);
        cycle(1, 999, 16'h0007);
        cur_tag = "R6/R8";
        cycle(1, 2500, 16'h0008);       // trigger
        chk(trig_flag == 1'b1, "R6 trigger visible next cycle", int'(trig_flag), 1);
        cycle(1, 1200, 16'h0009);
        cycle(0, 0, 0);
        cycle(1, 1300, 16'h000A);
        cycle(1, 3000, 16'h000B);
        cycle(1, 1400, 16'h000C);       // third post-trigger store
        chk(done_flag == 1'b0, "R8 done not yet", int'(done_flag), 0);
        cycle(1, 1500, 16'h000D);       // quota met: not stored
        chk(done_flag == 1'b1, "R8 done after quota", int'(done_flag), 1);
        cycle(1, 1000, 16'h000E);       // ignored after done
        chk(mem_we == 1'b0, "R9 sample after done ignored", int'(mem_we), 0);
        drain("R8 post-trigger writes");

        // R4 discard window inside keep-all default, inclusive bounds
        cur_tag = "R4";
        clear_steps();
        dflt_store = 1'b1;
        post_cnt = 11'd2047;
        cfg_write(0, 0, 10);
        cfg_write(0, 1, 20);
        cfg_write(0, 3, 'h01);
        do_arm();
        cycle(1, 9, 16'h0B09);
        cycle(1, 10, 16'h0B0A);
        cycle(1, 15, 16'h0B0F);
        cycle(1, 20, 16'h0B14);
        cycle(1, 21, 16'h0B15);
        drain("R4 discard window");

        // R2 re-arm mid-run restarts the write pointer
        cur_tag = "R2";
        for (int i = 0; i < 5; i++) cycle(1, 100 + i, 16'h0C00 + i);
        do_arm();
        for (int i = 0; i < 3; i++) cycle(1, 200 + i, 16'h0D00 + i);
        drain("R2 pointer restart");

        // R7 pointer wraps at 1024
        cur_tag = "R7 wrap";
        clear_steps();
        do_arm();
        for (int i = 0; i < 1030; i++) cycle(1, 300, i);
        drain("R7 wrap writes");

        // R8 zero post-count: done one edge after trigger
        cur_tag = "R8 zero";
        post_cnt = 11'd0;
        cfg_write(0, 2, 7);
        cfg_write(0, 3, 'h0C);          // trigger, stay in step 0
        do_arm();
        cycle(1, 3, 16'h0E03);
        cycle(1, 7, 16'h0E07);
        chk(trig_flag == 1'b1 && done_flag == 1'b0, "R6 trigger before done", int'(done_flag), 0);
        cycle(1, 8, 16'h0E08);          // not stored
        chk(done_flag == 1'b1, "R8 zero post-count done", int'(done_flag), 1);
        drain("R8 zero post-count writes");

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule